// File: doc/BRIEF.md
# Bridge Legacy I/O Routing Decoder

This block makes the routing choice for the downstream port of a virtual PCI-to-PCI bridge. Each CPU-initiated request arrives as an address, a space flag (I/O or memory) and a valid strobe. One clock later the block reports one of two outcomes. The request is either claimed for the downstream port or left for the legacy/subtractive path. The response also says which rule made the claim.

Three rules take part:

- **I/O window.** A base/limit window covers the 16-bit I/O space in 4 KB steps.
- **ISA alias exclusion.** This optional mode removes the upper 768 bytes of every 1 KB block from the window.
- **VGA forwarding.** This mode claims the legacy display I/O ranges and the display memory aperture. The I/O ranges can be matched on 10 address bits, so aliases also match, or on the full 16 bits.

A small register port holds the control bits and the window bounds. Software programs these before traffic is routed.

Top module: `io_route_decoder`

## Requirements
- R1: After reset the control register reads 0, the window base reads 4'hF and the window limit reads 4'h0. No request is claimed until software programs the registers.
- R2: Each request with `req_valid` high gives `rsp_valid` high on the next clock, with its result. A cycle without a request gives `rsp_valid` and all result flags low on the next clock.
- R3: An I/O request falls inside the window when base <= addr[15:12] <= limit. The window is empty when base > limit. Address bits above 15 are ignored for I/O. A memory request never hits the window.
- R4: When control bit 0 (ISA exclusion) is set, an I/O address inside the window with addr[9:8] != 0 is not claimed by the window. When bit 0 is clear, every in-window I/O address is claimed.
- R5: When control bit 1 (VGA enable) is set and control bit 2 is clear, an I/O request is claimed as VGA when addr[9:0] lies in 3B0h..3BBh or 3C0h..3DFh. This makes the aliases in every 1 KB block match.
- R6: When control bits 1 and 2 are both set, VGA I/O matching also requires addr[15:10] == 0, so aliases are rejected. When bit 1 is clear, no VGA range is claimed, whatever the value of bit 2.
- R7: When control bit 1 is set, a memory request with address in A0000h..BFFFFh is claimed as VGA.
- R8: ISA exclusion never blocks a VGA match. `rsp_forward` is high exactly when `rsp_hit_window` or `rsp_hit_vga` is high, and both flags may be high together.
- R9: Control bit 3 (abort mode) always reads 0, and writes to it are ignored.
- R10: The register map is as follows. Address 0 holds the control bits [3:0]. Address 1 holds the window base in bits [3:0]. Address 2 holds the window limit in bits [3:0]. Address 3 and all unused bits read 0. A write takes effect at the clock edge on which `reg_wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational from the register flops) |
| req_valid | input | 1 | Request strobe |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Result valid, one clock after the request |
| rsp_forward | output | 1 | Request is claimed for the downstream port |
| rsp_hit_window | output | 1 | Claim made by the I/O window |
| rsp_hit_vga | output | 1 | Claim made by a VGA range |

## Verification
The routing state is held in the control, base and limit flops, and a fault there shows up at the ports in two ways:

- **Read-back.** A corrupted control bit or window bound appears in `reg_rdata` in the same cycle the register is selected.
- **Routing.** The same fault shows in the result flags of the very next request that touches that rule.

The stimulus walks the window edges, the 1 KB alias boundaries, the VGA range edges and the memory aperture edges. A stuck bit in a comparator or a wrong decode width therefore flips `rsp_forward` on the first request past the faulty boundary, one clock after it is issued. A fault in the result register shows up on the first back-to-back or idle cycle.

// File: rtl/io_route_pkg.sv
package io_route_pkg;

  localparam int ADDR_W       = 32;
  localparam int IO_W         = 16;
  localparam int GRAN_LOG2    = 12;
  localparam int ALIAS_BITS   = 10;
  localparam int ISA_SEL_LO   = 8;
  localparam int WIN_W        = IO_W - GRAN_LOG2;
  localparam int DATA_W       = 16;
  localparam int REG_AW       = 2;

  localparam logic [REG_AW-1:0] RA_CTRL  = 2'd0;
  localparam logic [REG_AW-1:0] RA_BASE  = 2'd1;
  localparam logic [REG_AW-1:0] RA_LIMIT = 2'd2;

  localparam int CB_ISA   = 0;
  localparam int CB_VGA   = 1;
  localparam int CB_FULL  = 2;
  localparam int CB_ABORT = 3;

  localparam int NUM_VGA_IO = 2;
  localparam logic [ALIAS_BITS-1:0] VGA_IO_LO [NUM_VGA_IO] = '{10'h3B0, 10'h3C0};
  localparam logic [ALIAS_BITS-1:0] VGA_IO_HI [NUM_VGA_IO] = '{10'h3BB, 10'h3DF};

  localparam logic [ADDR_W-1:0] VGA_MEM_LO = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] VGA_MEM_HI = 32'h000B_FFFF;

  typedef struct packed {
    logic             vga_full;
    logic             vga_en;
    logic             isa_excl;
    logic [WIN_W-1:0] base;
    logic [WIN_W-1:0] limit;
  } route_cfg_t;

endpackage

// File: rtl/route_cfg_regs.sv
module route_cfg_regs
  import io_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output route_cfg_t        cfg
);

  route_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.isa_excl <= 1'b0;
      cfg_q.vga_en   <= 1'b0;
      cfg_q.vga_full <= 1'b0;
      cfg_q.base     <= '1;
      cfg_q.limit    <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_CTRL: begin
          cfg_q.isa_excl <= wdata[CB_ISA];
          cfg_q.vga_en   <= wdata[CB_VGA];
          cfg_q.vga_full <= wdata[CB_FULL];
        end
        RA_BASE:  cfg_q.base  <= wdata[WIN_W-1:0];
        RA_LIMIT: cfg_q.limit <= wdata[WIN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL: begin
        rdata[CB_ISA]   = cfg_q.isa_excl;
        rdata[CB_VGA]   = cfg_q.vga_en;
        rdata[CB_FULL]  = cfg_q.vga_full;
        rdata[CB_ABORT] = 1'b0;
      end
      RA_BASE:  rdata[WIN_W-1:0] = cfg_q.base;
      RA_LIMIT: rdata[WIN_W-1:0] = cfg_q.limit;
      default:  rdata = '0;
    endcase
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/io_window_match.sv
module io_window_match
  import io_route_pkg::*;
(
  input  logic            is_io,
  input  logic [IO_W-1:0] io_addr,
  input  logic [WIN_W-1:0] base,
  input  logic [WIN_W-1:0] limit,
  input  logic            isa_excl,
  output logic            claim
);

  logic [WIN_W-1:0] page;
  logic             in_range;
  logic             upper_quarter;

  assign page          = io_addr[IO_W-1:GRAN_LOG2];
  assign in_range      = (page >= base) && (page <= limit);
  assign upper_quarter = |io_addr[ALIAS_BITS-1:ISA_SEL_LO];
  assign claim         = is_io && in_range && !(isa_excl && upper_quarter);

endmodule

// File: rtl/vga_range_match.sv
module vga_range_match
  import io_route_pkg::*;
(
  input  logic              is_io,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vga_en,
  input  logic              vga_full,
  output logic              claim
);

  logic [NUM_VGA_IO-1:0] io_hit;
  logic                  alias_ok;
  logic                  io_claim;
  logic                  mem_claim;

  for (genvar g = 0; g < NUM_VGA_IO; g++) begin : g_io_rng
    assign io_hit[g] = (addr[ALIAS_BITS-1:0] >= VGA_IO_LO[g]) &&
                       (addr[ALIAS_BITS-1:0] <= VGA_IO_HI[g]);
  end

  assign alias_ok  = !vga_full || (addr[IO_W-1:ALIAS_BITS] == '0);
  assign io_claim  = is_io && (|io_hit) && alias_ok;
  assign mem_claim = !is_io && (addr >= VGA_MEM_LO) && (addr <= VGA_MEM_HI);
  assign claim     = vga_en && (io_claim || mem_claim);

endmodule

// File: rtl/io_route_decoder.sv
module io_route_decoder
  import io_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_valid,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_forward,
  output logic              rsp_hit_window,
  output logic              rsp_hit_vga
);

  route_cfg_t cfg;
  logic       cfg_isa, cfg_vga, cfg_full;
  logic       win_claim, vga_claim;

  route_cfg_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  assign cfg_isa  = cfg.isa_excl;
  assign cfg_vga  = cfg.vga_en;
  assign cfg_full = cfg.vga_full;

  io_window_match u_win (
    .is_io    (req_is_io),
    .io_addr  (req_addr[IO_W-1:0]),
    .base     (cfg.base),
    .limit    (cfg.limit),
    .isa_excl (cfg_isa),
    .claim    (win_claim)
  );

  vga_range_match u_vga (
    .is_io    (req_is_io),
    .addr     (req_addr),
    .vga_en   (cfg_vga),
    .vga_full (cfg_full),
    .claim    (vga_claim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_forward    <= 1'b0;
      rsp_hit_window <= 1'b0;
      rsp_hit_vga    <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_forward    <= req_valid && (win_claim || vga_claim);
      rsp_hit_window <= req_valid && win_claim;
      rsp_hit_vga    <= req_valid && vga_claim;
    end
  end

endmodule

// File: rtl/io_route_chk.sv
module io_route_chk
  import io_route_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_is_io,
  input logic [ADDR_W-1:0] req_addr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              cfg_isa,
  input logic              cfg_vga,
  input logic              rsp_valid,
  input logic              rsp_forward,
  input logic              rsp_hit_window,
  input logic              rsp_hit_vga
);

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_forward && !rsp_hit_window && !rsp_hit_vga);

  p_mem_no_window_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_io) |=> !rsp_hit_window);

  p_isa_blocks_window_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_io && cfg_isa && (req_addr[9:8] != 2'b00)) |=> !rsp_hit_window);

  p_vga_off_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cfg_vga) |=> !rsp_hit_vga);

  p_forward_flags_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_forward == (rsp_hit_window || rsp_hit_vga)));

  p_abort_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == RA_CTRL) |-> !reg_rdata[CB_ABORT]);

endmodule

bind io_route_decoder io_route_chk chk_i (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_is_io      (req_is_io),
  .req_addr       (req_addr),
  .reg_addr       (reg_addr),
  .reg_rdata      (reg_rdata),
  .cfg_isa        (cfg_isa),
  .cfg_vga        (cfg_vga),
  .rsp_valid      (rsp_valid),
  .rsp_forward    (rsp_forward),
  .rsp_hit_window (rsp_hit_window),
  .rsp_hit_vga    (rsp_hit_vga)
);

// File: tb/io_route_decoder_tb_top.sv
module io_route_decoder_tb_top;

  localparam int CLK_P = 10;
  localparam int VEC_N = 23;

  typedef struct packed {
    logic [3:0]  ctrl;
    logic [3:0]  base;
    logic [3:0]  lim;
    logic        io;
    logic [31:0] addr;
    logic        fwd;
    logic        win;
    logic        vga;
  } vec_t;

  // ctrl: bit0 ISA exclusion, bit1 VGA enable, bit2 16-bit VGA decode
  localparam vec_t VEC [VEC_N] = '{
    '{4'h0, 4'h1, 4'h2, 1'b1, 32'h0000_1000, 1'b1, 1'b1, 1'b0}, // R3 window low edge
    '{4'h0, 4'h1, 4'h2, 1'b1, 32'h0000_1300, 1'b1, 1'b1, 1'b0}, // R4 exclusion off
    '{4'h1, 4'h1, 4'h2, 1'b1, 32'h0000_1300, 1'b0, 1'b0, 1'b0}, // R4 upper quarter blocked
    '{4'h1, 4'h1, 4'h2, 1'b1, 32'h0000_10FF, 1'b1, 1'b1, 1'b0}, // R4 lower quarter kept
    '{4'h1, 4'h1, 4'h2, 1'b1, 32'h0000_2C40, 1'b1, 1'b1, 1'b0}, // R4 lower quarter top page
    '{4'h0, 4'h1, 4'h2, 1'b1, 32'h0000_3000, 1'b0, 1'b0, 1'b0}, // R3 above limit
    '{4'h0, 4'h1, 4'h2, 1'b1, 32'h0000_0FFF, 1'b0, 1'b0, 1'b0}, // R3 below base
    '{4'h2, 4'h1, 4'h2, 1'b1, 32'h0000_03B0, 1'b1, 1'b0, 1'b1}, // R5 first range low
    '{4'h2, 4'h1, 4'h2, 1'b1, 32'h0000_07C5, 1'b1, 1'b0, 1'b1}, // R5 10-bit alias
    '{4'h6, 4'h1, 4'h2, 1'b1, 32'h0000_07C5, 1'b0, 1'b0, 1'b0}, // R6 alias rejected
    '{4'h6, 4'h1, 4'h2, 1'b1, 32'h0000_03DF, 1'b1, 1'b0, 1'b1}, // R6 second range high
    '{4'h6, 4'h1, 4'h2, 1'b1, 32'h0000_03BC, 1'b0, 1'b0, 1'b0}, // R5 gap between ranges
    '{4'h4, 4'h1, 4'h2, 1'b1, 32'h0000_03C0, 1'b0, 1'b0, 1'b0}, // R6 full decode without enable
    '{4'h3, 4'h0, 4'h0, 1'b1, 32'h0000_03B5, 1'b1, 1'b0, 1'b1}, // R8 exclusion does not block VGA
    '{4'h2, 4'h1, 4'h2, 1'b0, 32'h000A_0000, 1'b1, 1'b0, 1'b1}, // R7 aperture low
    '{4'h2, 4'h1, 4'h2, 1'b0, 32'h000B_FFFF, 1'b1, 1'b0, 1'b1}, // R7 aperture high
    '{4'h2, 4'h1, 4'h2, 1'b0, 32'h000C_0000, 1'b0, 1'b0, 1'b0}, // R7 past aperture
    '{4'h0, 4'h1, 4'h2, 1'b0, 32'h000A_0000, 1'b0, 1'b0, 1'b0}, // R7 aperture with VGA off
    '{4'h0, 4'h3, 4'h2, 1'b1, 32'h0000_2000, 1'b0, 1'b0, 1'b0}, // R3 empty window
    '{4'h0, 4'h5, 4'h5, 1'b0, 32'h0000_5000, 1'b0, 1'b0, 1'b0}, // R3 memory not in window
    '{4'h2, 4'h1, 4'h2, 1'b1, 32'h0000_13C0, 1'b1, 1'b1, 1'b1}, // R8 both flags
    '{4'h2, 4'h1, 4'h2, 1'b1, 32'h0000_0399, 1'b0, 1'b0, 1'b0}, // R5 below first range
    '{4'h6, 4'h1, 4'h2, 1'b1, 32'h0001_03B0, 1'b1, 1'b0, 1'b1}  // R3 upper I/O bits ignored
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_is_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_forward, rsp_hit_window, rsp_hit_vga;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_P/2) clk = ~clk;

  io_route_decoder dut_i (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_forward(rsp_forward),
    .rsp_hit_window(rsp_hit_window), .rsp_hit_vga(rsp_hit_vga)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // result packed as {valid, forward, window, vga}
  task automatic req(input logic io, input logic [31:0] a, output logic [3:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_is_io = io; req_addr = a;
    @(negedge clk);
    r = {rsp_valid, rsp_forward, rsp_hit_window, rsp_hit_vga};
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [3:0]  r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values and no claim
    rd(2'd0, d); check("R1 ctrl reset", d, 16'h0000);
    rd(2'd1, d); check("R1 base reset", d, 16'h000F);
    rd(2'd2, d); check("R1 limit reset", d, 16'h0000);
    req(1'b1, 32'h0000_0000, r); check("R1 io after reset", {12'h0, r}, 16'h0008);
    req(1'b0, 32'h000A_0000, r); check("R1 mem after reset", {12'h0, r}, 16'h0008);

    // R2 idle cycle gives quiet response
    @(negedge clk); @(negedge clk);
    check("R2 idle", {12'h0, rsp_valid, rsp_forward, rsp_hit_window, rsp_hit_vga}, 16'h0000);

    // vector table
    for (int i = 0; i < VEC_N; i++) begin
      wr(2'd0, {12'h0, VEC[i].ctrl});
      wr(2'd1, {12'h0, VEC[i].base});
      wr(2'd2, {12'h0, VEC[i].lim});
      req(VEC[i].io, VEC[i].addr, r);
      check($sformatf("R3-table vector %0d", i), {12'h0, r},
            {12'h0, 1'b1, VEC[i].fwd, VEC[i].win, VEC[i].vga});
    end

    // R9 abort bit reads 0 and write ignored; R10 map
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); check("R9 abort bit masked", d, 16'h0007);
    wr(2'd1, 16'hFFF3);
    rd(2'd1, d); check("R10 base width", d, 16'h0003);
    wr(2'd2, 16'h00A9);
    rd(2'd2, d); check("R10 limit width", d, 16'h0009);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, d); check("R10 unused address", d, 16'h0000);

    // R2 back-to-back requests: window 3..9, ISA on, VGA full decode
    @(negedge clk);
    req_valid = 1'b1; req_is_io = 1'b1; req_addr = 32'h0000_4000;
    @(negedge clk);
    check("R2 b2b first", {12'h0, rsp_valid, rsp_forward, rsp_hit_window, rsp_hit_vga}, 16'h000E);
    req_addr = 32'h0000_4100;
    @(negedge clk);
    check("R4 b2b second", {12'h0, rsp_valid, rsp_forward, rsp_hit_window, rsp_hit_vga}, 16'h0008);
    req_is_io = 1'b0; req_addr = 32'h000B_0000;
    @(negedge clk);
    check("R7 b2b third", {12'h0, rsp_valid, rsp_forward, rsp_hit_window, rsp_hit_vga}, 16'h000D);
    req_valid = 1'b0;
    @(negedge clk);
    check("R2 b2b drain", {12'h0, rsp_valid, rsp_forward, rsp_hit_window, rsp_hit_vga}, 16'h0000);

    // R10 write takes effect at its own edge: clear VGA then request aperture
    wr(2'd0, 16'h0000);
    req(1'b0, 32'h000B_0000, r); check("R10 ctrl write effective", {12'h0, r}, 16'h0008);

    // R1 reset returns registers to defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(2'd1, d); check("R1 base after re-reset", d, 16'h000F);
    req(1'b1, 32'h0000_0000, r); check("R1 empty after re-reset", {12'h0, r}, 16'h0008);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule